// File: doc/BRIEF.md
# VirtIO Configuration-Window Access Bridge

This block sits on the application side of a PCI Express endpoint. The host driver reaches device registers indirectly, through a small data window in configuration space. It first programs a BAR index, an access length and a BAR offset, then reads or writes the window. The bridge receives each such access as a one-cycle read or write strobe. With the strobe come the window parameters, the 32-bit window data and the identity of the target function: physical function number, virtual function number and a flag that marks a virtual-function access.

For every strobe the bridge checks the parameters and issues one sized access on a simple local BAR register bus. That access carries the BAR index, a word address, byte enables and lane-aligned write data. A read completes with a single-cycle acknowledge. The returned bytes are right-justified, and the acknowledge carries the function identity of the request that produced it.

The bridge serves one request at a time. Strobes that arrive while a read is still in flight are queued and served in order after its acknowledge. The local bus has a fixed read latency of one cycle: read data is valid on the cycle after the access.

Top module: `vcw_window_bridge`

## Requirements
- R1: For an accepted request, the local byte enables are 4'b0001 shifted left by offset[1:0] for length 1, 4'b0011 shifted left by offset[1:0] for length 2, and 4'b1111 for length 4. Write data is placed on the same byte lanes.
- R2: A valid write strobe causes exactly one local access with the write flag set. Only the lowest `length` bytes of the window data reach the BAR, at the byte offset given.
- R3: A valid read strobe returns the `length` bytes at the offset, right-justified in the response data, with all higher bytes zero.
- R4: A request with a BAR index above 5, a length other than 1, 2 or 4, or an offset that is not a multiple of the length raises the error pulse for one cycle and issues no local access. A local access never carries a BAR index above 5.
- R5: A read request that fails the checks of R4 is still acknowledged, with zero response data.
- R6: Every read gets exactly one acknowledge, one cycle wide, no more than 10 cycles after its strobe. A write gets no acknowledge.
- R7: The acknowledge carries the physical function number, the virtual-function flag and the virtual function number of its request. The virtual function number is reported as 0 when the flag is clear. All response fields are zero while the acknowledge is low.
- R8: The response byte-enable output is always 4'b1111.
- R9: At most one local access is in progress at a time. A strobe that arrives while a read is pending is held, and its local access comes after the pending acknowledge.
- R10: After synchronous reset the local access enable, error pulse, acknowledge and response data are all low.
- R11: An accepted access presents BAR index bits [2:0] on the local BAR select and offset bits [LOC_AW+1:2] as the local word address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_wr | input | 1 | Driver write to the data window (one-cycle strobe) |
| win_rd | input | 1 | Driver read from the data window (one-cycle strobe) |
| win_bar | input | 8 | BAR index of the window |
| win_len | input | 32 | Access length in bytes |
| win_off | input | 32 | Byte offset inside the BAR |
| win_data | input | 32 | Window write data |
| win_pf | input | PF_W | Target physical function |
| win_vf | input | VF_W | Target virtual function |
| win_vf_act | input | 1 | Access targets a virtual function |
| loc_en | output | 1 | Local access strobe |
| loc_we | output | 1 | Local access is a write |
| loc_bar | output | 3 | Local BAR select |
| loc_addr | output | LOC_AW | Local word address |
| loc_be | output | 4 | Local byte enables |
| loc_wdata | output | 32 | Local write data, lane-aligned |
| loc_pf | output | PF_W | Function of the local access |
| loc_vf | output | VF_W | Virtual function of the local access (0 if none) |
| loc_vf_act | output | 1 | Local access targets a virtual function |
| loc_rdata | input | 32 | Local read data, valid one cycle after loc_en |
| acc_err | output | 1 | One-cycle pulse for a rejected request |
| rsp_ack | output | 1 | Read acknowledge |
| rsp_be | output | 4 | Response byte enables |
| rsp_data | output | 32 | Right-justified read data |
| rsp_pf | output | PF_W | Physical function of the acknowledged read |
| rsp_vf | output | VF_W | Virtual function of the acknowledged read |
| rsp_vf_act | output | 1 | Acknowledged read targeted a virtual function |

## Verification
Several properties are checked on every cycle:
- the byte-enable shape, with one, two or four lanes set;
- that no local access ever selects a BAR above 5;
- the spacing of local accesses;
- the single-cycle acknowledge and its latency bound;
- that response fields are zero outside the acknowledge;
- that the request queue never overflows or underflows.

Some behaviour only the bench's scenarios can show. This covers the exact lane placement of write data and the right-justified read contents against a modelled BAR. It also covers the suppression of writes for rejected requests, seen when the untouched word is read back. Finally, the scenarios show that a write queued behind a pending read reaches the bus only after that read's acknowledge.

// File: rtl/vcw_pkg.sv
package vcw_pkg;
  localparam int unsigned WIN_BYTES = 4;
  localparam int unsigned MAX_BAR   = 5;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_ISSUE = 2'd1,
    ENG_CAPT  = 2'd2
  } eng_state_e;

  typedef struct packed {
    logic        ok;
    logic [3:0]  be;
    logic [1:0]  lane;
    logic [31:0] mask;
  } dec_t;
endpackage

// File: rtl/vcw_req_fifo.sv
module vcw_req_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] used;

  assign empty = (used == '0);
  assign full  = (used == CW'(DEPTH));
  assign head  = store[rd_ptr];

  // storage without reset so it maps to RAM
  always_ff @(posedge clk) begin
    if (push && !full) store[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      used   <= '0;
    end else begin
      if (push && !full) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop && !empty) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push && !full, pop && !empty})
        2'b10:   used <= used + 1'b1;
        2'b01:   used <= used - 1'b1;
        default: used <= used;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) push |-> !full); // R9
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) pop |-> !empty); // R9
endmodule

// File: rtl/vcw_decode.sv
module vcw_decode
  import vcw_pkg::*;
(
  input  logic [7:0]  bar,
  input  logic [31:0] len,
  input  logic [31:0] off,
  output dec_t        dec
);
  logic [2:0] nbytes;
  logic       aligned;
  logic [3:0] base_be;
  logic [31:0] mask;

  always_comb begin
    nbytes  = 3'd0;
    base_be = 4'b0000;
    aligned = 1'b0;
    unique case (len)
      32'd1: begin nbytes = 3'd1; base_be = 4'b0001; aligned = 1'b1; end
      32'd2: begin nbytes = 3'd2; base_be = 4'b0011; aligned = (off[0] == 1'b0); end
      32'd4: begin nbytes = 3'd4; base_be = 4'b1111; aligned = (off[1:0] == 2'b00); end
      default: begin nbytes = 3'd0; base_be = 4'b0000; aligned = 1'b0; end
    endcase
  end

  for (genvar b = 0; b < WIN_BYTES; b++) begin : g_mask
    assign mask[8*b +: 8] = (3'(b) < nbytes) ? 8'hFF : 8'h00;
  end

  assign dec.ok   = (nbytes != 3'd0) && aligned && (bar <= 8'(MAX_BAR));
  assign dec.lane = off[1:0];
  assign dec.be   = base_be << off[1:0];
  assign dec.mask = mask;
endmodule

// File: rtl/vcw_rd_align.sv
module vcw_rd_align
  import vcw_pkg::*;
(
  input  logic [31:0] rdata,
  input  logic [1:0]  lane,
  input  logic [31:0] mask,
  input  logic        ok,
  output logic [31:0] data
);
  logic [31:0] shifted;

  for (genvar b = 0; b < WIN_BYTES; b++) begin : g_lane
    logic [2:0] src;
    assign src = 3'(b) + {1'b0, lane};
    always_comb begin
      if (src < 3'(WIN_BYTES)) shifted[8*b +: 8] = rdata[8*src[1:0] +: 8];
      else                     shifted[8*b +: 8] = 8'h00;
    end
  end

  assign data = ok ? (shifted & mask) : 32'h0;
endmodule

// File: rtl/vcw_window_bridge.sv
module vcw_window_bridge
  import vcw_pkg::*;
#(
  parameter int unsigned PF_W       = 3,
  parameter int unsigned VF_W       = 11,
  parameter int unsigned LOC_AW     = 10,
  parameter int unsigned HOLD_DEPTH = 2,
  parameter int unsigned ACK_MAX    = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              win_wr,
  input  logic              win_rd,
  input  logic [7:0]        win_bar,
  input  logic [31:0]       win_len,
  input  logic [31:0]       win_off,
  input  logic [31:0]       win_data,
  input  logic [PF_W-1:0]   win_pf,
  input  logic [VF_W-1:0]   win_vf,
  input  logic              win_vf_act,
  output logic              loc_en,
  output logic              loc_we,
  output logic [2:0]        loc_bar,
  output logic [LOC_AW-1:0] loc_addr,
  output logic [3:0]        loc_be,
  output logic [31:0]       loc_wdata,
  output logic [PF_W-1:0]   loc_pf,
  output logic [VF_W-1:0]   loc_vf,
  output logic              loc_vf_act,
  input  logic [31:0]       loc_rdata,
  output logic              acc_err,
  output logic              rsp_ack,
  output logic [3:0]        rsp_be,
  output logic [31:0]       rsp_data,
  output logic [PF_W-1:0]   rsp_pf,
  output logic [VF_W-1:0]   rsp_vf,
  output logic              rsp_vf_act
);
  localparam int unsigned REQ_W = 1 + 8 + 32 + 32 + 32 + PF_W + VF_W + 1;
  localparam int unsigned AGE_W = $clog2(ACK_MAX + 2) + 1;

  logic             push, pop, q_empty, q_full;
  logic [REQ_W-1:0] q_in, q_head;

  logic              h_wr, h_vfa;
  logic [7:0]        h_bar;
  logic [31:0]       h_len, h_off, h_data;
  logic [PF_W-1:0]   h_pf;
  logic [VF_W-1:0]   h_vf;

  dec_t              dec;
  eng_state_e        state;
  logic              cur_wr, cur_ok, cur_vfa;
  logic [1:0]        cur_lane;
  logic [31:0]       cur_mask, aligned;
  logic [PF_W-1:0]   cur_pf;
  logic [VF_W-1:0]   cur_vf;
  logic [AGE_W-1:0]  rd_age;

  assign push = win_wr | win_rd;
  assign q_in = {win_wr, win_bar, win_len, win_off, win_data, win_pf, win_vf, win_vf_act};
  assign {h_wr, h_bar, h_len, h_off, h_data, h_pf, h_vf, h_vfa} = q_head;
  assign pop  = (state == ENG_IDLE) && !q_empty;

  vcw_req_fifo #(.W(REQ_W), .DEPTH(HOLD_DEPTH)) u_hold (
    .clk(clk), .rst(rst), .push(push), .push_data(q_in), .pop(pop),
    .head(q_head), .empty(q_empty), .full(q_full)
  );

  vcw_decode u_dec (.bar(h_bar), .len(h_len), .off(h_off), .dec(dec));

  vcw_rd_align u_align (
    .rdata(loc_rdata), .lane(cur_lane), .mask(cur_mask), .ok(cur_ok), .data(aligned)
  );

  assign rsp_be = 4'hF;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ENG_IDLE;
      loc_en     <= 1'b0;
      loc_we     <= 1'b0;
      loc_bar    <= '0;
      loc_addr   <= '0;
      loc_be     <= '0;
      loc_wdata  <= '0;
      loc_pf     <= '0;
      loc_vf     <= '0;
      loc_vf_act <= 1'b0;
      acc_err    <= 1'b0;
      rsp_ack    <= 1'b0;
      rsp_data   <= '0;
      rsp_pf     <= '0;
      rsp_vf     <= '0;
      rsp_vf_act <= 1'b0;
      cur_wr     <= 1'b0;
      cur_ok     <= 1'b0;
      cur_vfa    <= 1'b0;
      cur_lane   <= '0;
      cur_mask   <= '0;
      cur_pf     <= '0;
      cur_vf     <= '0;
    end else begin
      loc_en     <= 1'b0;
      acc_err    <= 1'b0;
      rsp_ack    <= 1'b0;
      rsp_data   <= '0;
      rsp_pf     <= '0;
      rsp_vf     <= '0;
      rsp_vf_act <= 1'b0;
      unique case (state)
        ENG_IDLE: begin
          if (!q_empty) begin
            cur_wr     <= h_wr;
            cur_ok     <= dec.ok;
            cur_lane   <= dec.lane;
            cur_mask   <= dec.mask;
            cur_pf     <= h_pf;
            cur_vf     <= h_vfa ? h_vf : '0;
            cur_vfa    <= h_vfa;
            loc_en     <= dec.ok;
            loc_we     <= h_wr;
            loc_bar    <= h_bar[2:0];
            loc_addr   <= h_off[LOC_AW+1:2];
            loc_be     <= dec.be;
            loc_wdata  <= (h_data & dec.mask) << {dec.lane, 3'b000};
            loc_pf     <= h_pf;
            loc_vf     <= h_vfa ? h_vf : '0;
            loc_vf_act <= h_vfa;
            acc_err    <= !dec.ok;
            state      <= ENG_ISSUE;
          end
        end
        ENG_ISSUE: state <= cur_wr ? ENG_IDLE : ENG_CAPT;
        ENG_CAPT: begin
          rsp_ack    <= 1'b1;
          rsp_data   <= aligned;
          rsp_pf     <= cur_pf;
          rsp_vf     <= cur_vf;
          rsp_vf_act <= cur_vfa;
          state      <= ENG_IDLE;
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

  // age of the read in service, used only to bound the acknowledge latency
  always_ff @(posedge clk) begin
    if (rst)                        rd_age <= '0;
    else if (pop && !h_wr)          rd_age <= AGE_W'(1);
    else if (state != ENG_IDLE && rd_age != '0) rd_age <= rd_age + 1'b1;
    else                            rd_age <= '0;
  end

  AST_BE_SHAPE: assert property (@(posedge clk) disable iff (rst)
    loc_en |-> ($countones(loc_be) == 1 || $countones(loc_be) == 2 || $countones(loc_be) == 4)); // R1
  AST_BAR_RANGE: assert property (@(posedge clk) disable iff (rst)
    loc_en |-> (loc_bar <= 3'(MAX_BAR))); // R4
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_ack |=> !rsp_ack); // R6
  AST_ACK_LATENCY: assert property (@(posedge clk) disable iff (rst)
    rsp_ack |-> (rd_age <= AGE_W'(ACK_MAX))); // R6
  AST_RSP_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rsp_ack |-> (rsp_data == '0 && rsp_pf == '0 && rsp_vf == '0 && !rsp_vf_act)); // R7
  AST_VF_GATED: assert property (@(posedge clk) disable iff (rst)
    (rsp_ack && !rsp_vf_act) |-> (rsp_vf == '0)); // R7
  AST_SINGLE_ACCESS: assert property (@(posedge clk) disable iff (rst)
    loc_en |=> !loc_en); // R9
  AST_NO_ACCESS_ON_ERR: assert property (@(posedge clk) disable iff (rst)
    acc_err |-> !loc_en); // R4
endmodule

// File: tb/sim_vcw_window_bridge.sv
module sim_vcw_window_bridge;
  localparam int unsigned PF_W = 3;
  localparam int unsigned VF_W = 11;
  localparam int unsigned LOC_AW = 10;
  localparam int NVEC = 18;

  typedef struct packed {
    logic        wr;
    logic [7:0]  bar;
    logic [7:0]  len;
    logic [7:0]  off;
    logic [31:0] data;
    logic [31:0] exp;
    logic        err;
  } vec_t;

  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 8'd0, 8'd4, 8'h00, 32'h11223344, 32'h0,        1'b0},
    '{1'b0, 8'd0, 8'd4, 8'h00, 32'h0,        32'h11223344, 1'b0},
    '{1'b1, 8'd0, 8'd1, 8'h01, 32'hFFFFFFAA, 32'h0,        1'b0},
    '{1'b0, 8'd0, 8'd4, 8'h00, 32'h0,        32'h1122AA44, 1'b0},
    '{1'b0, 8'd0, 8'd1, 8'h01, 32'h0,        32'h000000AA, 1'b0},
    '{1'b1, 8'd0, 8'd2, 8'h02, 32'hDEADBEEF, 32'h0,        1'b0},
    '{1'b0, 8'd0, 8'd2, 8'h02, 32'h0,        32'h0000BEEF, 1'b0},
    '{1'b0, 8'd0, 8'd4, 8'h00, 32'h0,        32'hBEEFAA44, 1'b0},
    '{1'b1, 8'd5, 8'd4, 8'h08, 32'hCAFEF00D, 32'h0,        1'b0},
    '{1'b0, 8'd5, 8'd4, 8'h08, 32'h0,        32'hCAFEF00D, 1'b0},
    '{1'b1, 8'd0, 8'd2, 8'h01, 32'h00005555, 32'h0,        1'b1},
    '{1'b0, 8'd0, 8'd4, 8'h02, 32'h0,        32'h0,        1'b1},
    '{1'b1, 8'd0, 8'd3, 8'h00, 32'h77777777, 32'h0,        1'b1},
    '{1'b0, 8'd0, 8'd4, 8'h00, 32'h0,        32'hBEEFAA44, 1'b0},
    '{1'b0, 8'd6, 8'd1, 8'h00, 32'h0,        32'h0,        1'b1},
    '{1'b0, 8'd5, 8'd1, 8'h0B, 32'h0,        32'h000000CA, 1'b0},
    '{1'b1, 8'd1, 8'd4, 8'h3C, 32'h0BADCAFE, 32'h0,        1'b0},
    '{1'b0, 8'd1, 8'd2, 8'h3E, 32'h0,        32'h00000BAD, 1'b0}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              win_wr = 1'b0, win_rd = 1'b0, win_vf_act = 1'b0;
  logic [7:0]        win_bar = '0;
  logic [31:0]       win_len = '0, win_off = '0, win_data = '0;
  logic [PF_W-1:0]   win_pf = '0;
  logic [VF_W-1:0]   win_vf = '0;
  logic              loc_en, loc_we, loc_vf_act, acc_err, rsp_ack, rsp_vf_act;
  logic [2:0]        loc_bar;
  logic [LOC_AW-1:0] loc_addr;
  logic [3:0]        loc_be, rsp_be;
  logic [31:0]       loc_wdata, rsp_data;
  logic [31:0]       loc_rdata = '0;
  logic [PF_W-1:0]   loc_pf, rsp_pf;
  logic [VF_W-1:0]   loc_vf, rsp_vf;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vcw_window_bridge #(.PF_W(PF_W), .VF_W(VF_W), .LOC_AW(LOC_AW)) u0 (
    .clk(clk), .rst(rst), .win_wr(win_wr), .win_rd(win_rd), .win_bar(win_bar),
    .win_len(win_len), .win_off(win_off), .win_data(win_data), .win_pf(win_pf),
    .win_vf(win_vf), .win_vf_act(win_vf_act), .loc_en(loc_en), .loc_we(loc_we),
    .loc_bar(loc_bar), .loc_addr(loc_addr), .loc_be(loc_be), .loc_wdata(loc_wdata),
    .loc_pf(loc_pf), .loc_vf(loc_vf), .loc_vf_act(loc_vf_act), .loc_rdata(loc_rdata),
    .acc_err(acc_err), .rsp_ack(rsp_ack), .rsp_be(rsp_be), .rsp_data(rsp_data),
    .rsp_pf(rsp_pf), .rsp_vf(rsp_vf), .rsp_vf_act(rsp_vf_act)
  );

  // BAR storage model: six BARs of 16 words, one-cycle registered read
  logic [31:0] bar_mem [96];
  initial for (int i = 0; i < 96; i++) bar_mem[i] = '0;
  always @(posedge clk) begin
    if (loc_en) begin
      int idx;
      idx = int'(loc_bar) * 16 + int'(loc_addr[3:0]);
      loc_rdata <= bar_mem[idx];
      if (loc_we)
        for (int b = 0; b < 4; b++)
          if (loc_be[b]) bar_mem[idx][8*b +: 8] <= loc_wdata[8*b +: 8];
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_be(input logic [7:0] len, input logic [7:0] off);
    case (len)
      8'd1:    exp_be = 4'b0001 << off[1:0];
      8'd2:    exp_be = 4'b0011 << off[1:0];
      default: exp_be = 4'b1111;
    endcase
  endfunction

  // monitor results of one request
  int          m_acc, m_ack, m_err, m_ack_cyc, m_acc_cyc, m_wr_cyc;
  logic [3:0]  m_be, m_rbe;
  logic [2:0]  m_bar;
  logic [LOC_AW-1:0] m_addr;
  logic [31:0] m_data;
  logic [PF_W-1:0] m_pf;
  logic [VF_W-1:0] m_vf;
  logic        m_vfa, m_we;

  task automatic sample(input int k);
    if (loc_en) begin
      m_acc++; m_be = loc_be; m_bar = loc_bar; m_addr = loc_addr; m_we = loc_we; m_acc_cyc = k;
      if (loc_we) m_wr_cyc = k;
    end
    if (acc_err) m_err++;
    if (rsp_ack) begin
      m_ack++; m_ack_cyc = k; m_data = rsp_data; m_pf = rsp_pf; m_vf = rsp_vf;
      m_vfa = rsp_vf_act; m_rbe = rsp_be;
    end
  endtask

  task automatic clear_mon();
    m_acc = 0; m_ack = 0; m_err = 0; m_ack_cyc = -1; m_acc_cyc = -1; m_wr_cyc = -1;
  endtask

  task automatic drive(input logic wr, input logic [7:0] bar, input logic [7:0] len,
                       input logic [7:0] off, input logic [31:0] data,
                       input logic [PF_W-1:0] pf, input logic [VF_W-1:0] vf, input logic vfa);
    win_wr = wr; win_rd = !wr; win_bar = bar; win_len = 32'(len); win_off = 32'(off);
    win_data = data; win_pf = pf; win_vf = vf; win_vf_act = vfa;
  endtask

  task automatic idle_in();
    win_wr = 1'b0; win_rd = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: idle after reset
    check(!loc_en && !acc_err && !rsp_ack, "R10 control idle", {29'd0, loc_en, acc_err, rsp_ack}, 32'h0);
    check(rsp_data == 32'h0, "R10 rsp_data", rsp_data, 32'h0);
    check(rsp_be == 4'hF, "R8 rsp_be after reset", 32'(rsp_be), 32'hF);

    for (int i = 0; i < NVEC; i++) begin
      logic [PF_W-1:0] pf;
      logic [VF_W-1:0] vf;
      logic vfa;
      pf = PF_W'(i % 5); vf = VF_W'(100 + i); vfa = i[0];
      clear_mon();
      @(negedge clk);
      drive(VEC[i].wr, VEC[i].bar, VEC[i].len, VEC[i].off, VEC[i].data, pf, vf, vfa);
      for (int k = 1; k <= 14; k++) begin
        @(negedge clk);
        if (k == 1) idle_in();
        sample(k);
      end
      check(m_err == (VEC[i].err ? 1 : 0), $sformatf("R4 err pulse vec%0d", i), 32'(m_err), 32'(VEC[i].err));
      if (VEC[i].err) begin
        check(m_acc == 0, $sformatf("R4 no access vec%0d", i), 32'(m_acc), 32'h0);
      end else begin
        check(m_acc == 1 && m_we == VEC[i].wr, $sformatf("R2 one access vec%0d", i), 32'(m_acc), 32'h1);
        check(m_be == exp_be(VEC[i].len, VEC[i].off), $sformatf("R1 byte enables vec%0d", i),
              32'(m_be), 32'(exp_be(VEC[i].len, VEC[i].off)));
        check(m_bar == VEC[i].bar[2:0] && m_addr == LOC_AW'(VEC[i].off >> 2),
              $sformatf("R11 bar/addr vec%0d", i), {m_bar, 19'd0, m_addr}, {VEC[i].bar[2:0], 21'd0, VEC[i].off[7:2]});
      end
      if (VEC[i].wr) begin
        check(m_ack == 0, $sformatf("R6 no ack on write vec%0d", i), 32'(m_ack), 32'h0);
      end else begin
        check(m_ack == 1, $sformatf("R6 single ack vec%0d", i), 32'(m_ack), 32'h1);
        check(m_ack_cyc >= 1 && m_ack_cyc <= 10, $sformatf("R6 ack latency vec%0d", i), 32'(m_ack_cyc), 32'd10);
        check(m_data == VEC[i].exp, $sformatf("%s read data vec%0d", VEC[i].err ? "R5" : "R3", i), m_data, VEC[i].exp);
        check(m_pf == pf && m_vfa == vfa, $sformatf("R7 pf/flag echo vec%0d", i), {m_vfa, 28'd0, m_pf}, {vfa, 28'd0, pf});
        check(m_vf == (vfa ? vf : '0), $sformatf("R7 vf echo vec%0d", i), 32'(m_vf), 32'(vfa ? vf : '0));
        check(m_rbe == 4'hF, $sformatf("R8 rsp_be vec%0d", i), 32'(m_rbe), 32'hF);
      end
    end

    // R9: write arriving during a pending read is held until after the ack
    clear_mon();
    @(negedge clk);
    drive(1'b0, 8'd0, 8'd4, 8'h00, 32'h0, 3'd2, 11'd7, 1'b1);
    @(negedge clk);
    sample(1);
    drive(1'b1, 8'd0, 8'd4, 8'h04, 32'h600DF00D, 3'd3, 11'd0, 1'b0);
    for (int k = 2; k <= 16; k++) begin
      @(negedge clk);
      if (k == 2) idle_in();
      sample(k);
    end
    check(m_ack == 1 && m_data == 32'hBEEFAA44, "R9 pending read data", m_data, 32'hBEEFAA44);
    check(m_wr_cyc > m_ack_cyc && m_ack_cyc > 0, "R9 held write after ack", 32'(m_wr_cyc), 32'(m_ack_cyc + 1));
    check(m_acc == 2, "R9 both accesses issued", 32'(m_acc), 32'h2);

    clear_mon();
    @(negedge clk);
    drive(1'b0, 8'd0, 8'd4, 8'h04, 32'h0, 3'd1, 11'd0, 1'b0);
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      if (k == 1) idle_in();
      sample(k);
    end
    check(m_data == 32'h600DF00D, "R9 held write landed", m_data, 32'h600DF00D);
    check(m_vf == '0 && !m_vfa, "R7 vf zero without flag", 32'(m_vf), 32'h0);

    // R10: synchronous reset clears an in-flight read
    @(negedge clk);
    drive(1'b0, 8'd0, 8'd4, 8'h00, 32'h0, 3'd0, 11'd0, 1'b0);
    @(negedge clk);
    idle_in();
    rst = 1'b1;
    @(negedge clk);
    check(!rsp_ack && !loc_en && rsp_data == 32'h0, "R10 reset mid-read", {31'd0, rsp_ack}, 32'h0);
    rst = 1'b0;
    clear_mon();
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      sample(k);
    end
    check(m_ack == 0 && m_acc == 0, "R10 no stray ack after reset", 32'(m_ack), 32'h0);

    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule